// File: doc/BRIEF.md
# Split Dual 8-Bit Timer

This block is a timer core with one counter register that a mode bit reinterprets. In wide mode it is a single 16-bit up-counter with one reload value and one compare value. In split mode the same storage works as two independent 8-bit counters. Each half has its own reload byte, compare byte, run control and pair of event flags. A shared prescaler produces one tick for whichever counters are running, so both halves advance on the same tick.

The high half, or the whole counter in wide mode, is the primary channel. It is started and stopped by a small state machine with three states:
- `ST_IDLE`: stopped.
- `ST_RUN`: free running under the main run bit.
- `ST_SHOT`: single shot, running until its next overflow.

The transitions are:
- A control write selects `ST_RUN` when the run bit is set, `ST_SHOT` when only the shot bit is set, and `ST_IDLE` otherwise.
- A primary overflow in `ST_SHOT` returns the machine to `ST_IDLE`.
- A control write that flips the mode bit forces `ST_IDLE`.

The low half runs from its own low run bit, and only in split mode.

Each channel drives a waveform output that toggles on that channel's overflow and compare events. The primary output follows the primary channel in both modes. The secondary output follows the whole 16-bit counter in wide mode and the low half in split mode. Software reaches the block through one write port. The port addresses the counter, reload, compare and control registers and a write-one-to-clear flag register. The block raises one interrupt per channel.

Top module: `split_timer`

## Requirements
- R1: After reset the count, the reload and compare values, all flags, both interrupts and both output levels are 0, and the primary state is `ST_IDLE`.
- R2: In wide mode, while the primary state is `ST_RUN` or `ST_SHOT`, each tick adds one to the 16-bit count, carrying from the low byte into the high byte. A tick at FFFFh loads the 16-bit reload value and raises the primary overflow flag (flag bit 0).
- R3: In split mode each 8-bit half counts on its own. A tick at FFh loads that half's reload byte (reload bits [15:8] high, [7:0] low). A wrap of the low half never changes the high half.
- R4: Both halves advance on one shared tick that occurs once every 2^n clock cycles, where n is control bits [12:10].
- R5: The high half runs in `ST_RUN` or `ST_SHOT`. The low half runs only when control bit 2 (low run) is 1 and the block is in split mode.
- R6: Control bit 3 (shot), written with control bit 1 (run) at 0, enters `ST_SHOT`. The next primary overflow loads the reload value and returns to `ST_IDLE`, so counting stops. In split mode the shot affects only the high half.
- R7: A compare event is a counting tick at which the channel's count equals its compare value. Primary compare sets flag bit 1. Low overflow and low compare set flag bits 2 and 3, only in split mode. Writing address 4 clears the flags whose data bits [3:0] are 1. An event in the same cycle wins over the clear.
- R8: irq_pri is 1 when control bit 4 is 1 and flag bit 0 or 1 is set. irq_sec is 1 only in split mode, when control bit 5 is 1 and flag bit 2 or 3 is set. Control bit 5 has no effect in wide mode.
- R9: While an output's enable is 0 (control bit 7 primary, bit 9 secondary), its level copies its polarity bit (bit 6 or bit 8). While the enable is 1, the level toggles on its source's overflow or compare events. The secondary source is the whole counter in wide mode and the low half in split mode. A polarity change while the output is enabled has no effect.
- R10: A control write that changes the mode bit (control bit 0) forces `ST_IDLE`, clears the low run bit and clears all four flags, whatever run bits the write carries.
- R11: At one tick per clock in split mode, a high reload of FCh gives a high overflow every 4 ticks, and a low reload of E0h gives a low overflow every 32 ticks.
- R12: With a reload byte of 00h and a compare byte of FFh, the compare and overflow events fall on the same tick, and the output toggles once per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0 count, 1 reload, 2 compare, 3 control, 4 flag clear |
| wr_data | input | 16 | Write data |
| count_o | output | 16 | Current counter value |
| flags_o | output | 4 | {low compare, low overflow, primary compare, primary overflow} |
| irq_pri | output | 1 | Primary channel interrupt |
| irq_sec | output | 1 | Secondary channel interrupt |
| pri_out | output | 1 | Primary waveform level |
| pri_oe | output | 1 | Primary output enable |
| sec_out | output | 1 | Secondary waveform level |
| sec_oe | output | 1 | Secondary output enable |

## Verification
The counter is first run in wide mode from 00FEh, where a carry out of the low byte must reach the high byte. It is then run in split mode from the same kind of value, where the low byte must wrap alone; the two runs separate a shared carry chain from independent halves. Reloads of FCh and E0h running together measure the two overflow rates, and a single shot next to a running low half shows whether the shot leaks into the secondary counter. A reload of 00h with a compare of FFh separates one toggle per coincident event from a double toggle. A mode flip with the run bits set, and a wide-mode run with the secondary interrupt enable set, show whether stale state survives a mode change or the low-side controls leak into wide mode.

// File: rtl/split_timer_pkg.sv
`timescale 1ns/1ps
package split_timer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SHOT = 2'd2
    } run_state_t;

    typedef enum logic [2:0] {
        A_COUNT   = 3'd0,
        A_RELOAD  = 3'd1,
        A_COMPARE = 3'd2,
        A_CTRL    = 3'd3,
        A_CLEAR   = 3'd4
    } reg_addr_t;

    localparam int B_MODE    = 0;
    localparam int B_RUN     = 1;
    localparam int B_RUN_LO  = 2;
    localparam int B_SHOT    = 3;
    localparam int B_IEN_PRI = 4;
    localparam int B_IEN_SEC = 5;
    localparam int B_POL_PRI = 6;
    localparam int B_OE_PRI  = 7;
    localparam int B_POL_SEC = 8;
    localparam int B_OE_SEC  = 9;
    localparam int B_DIV_LO  = 10;
    localparam int DIV_W     = 3;
    localparam int FLAG_N    = 4;
endpackage

// File: rtl/split_timer_prescaler.sv
`timescale 1ns/1ps
module split_timer_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int PS_W = (1 << SEL_W) - 1;

    logic [PS_W-1:0] phase_q;
    logic [PS_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end

    always_comb begin
        mask = ~({PS_W{1'b1}} << div_sel);
        tick = (phase_q & mask) == mask;
    end
endmodule

// File: rtl/split_timer_half.sv
`timescale 1ns/1ps
module split_timer_half #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_val,
    input  logic [W-1:0] new_val,
    input  logic         en,
    input  logic         wrap,
    input  logic [W-1:0] reload,
    input  logic [W-1:0] compare,
    output logic [W-1:0] value,
    output logic         at_max,
    output logic         match
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        value <= '0;
        else if (load_val) value <= new_val;
        else if (en)       value <= wrap ? reload : value + 1'b1;
    end

    always_comb begin
        at_max = &value;
        match  = (value == compare);
    end
endmodule

// File: rtl/split_timer_wave.sv
`timescale 1ns/1ps
module split_timer_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic oe,
    input  logic pol,
    input  logic toggle,
    output logic level
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      level <= 1'b0;
        else if (!oe)    level <= pol;
        else if (toggle) level <= ~level;
    end
endmodule

// File: rtl/split_timer.sv
`timescale 1ns/1ps
module split_timer
    import split_timer_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [2*HALF_W-1:0] wr_data,
    output logic [2*HALF_W-1:0] count_o,
    output logic [FLAG_N-1:0]   flags_o,
    output logic                irq_pri,
    output logic                irq_sec,
    output logic                pri_out,
    output logic                pri_oe,
    output logic                sec_out,
    output logic                sec_oe
);
    localparam int CNT_W = 2 * HALF_W;
    localparam int NHALF = 2;

    run_state_t state_q, state_d;

    logic [CNT_W-1:0] reload_q, compare_q;
    logic             mode_q, run_lo_q, ien_pri_q, ien_sec_q;
    logic             pol_pri_q, oe_pri_q, pol_sec_q, oe_sec_q;
    logic [DIV_W-1:0] div_q;
    logic [FLAG_N-1:0] flags_q, clr_mask, ev_vec;

    logic ctrl_wr, cnt_wr, mode_flip, tick, hi_go, lo_go, full_max;
    logic pri_ovf_ev, pri_cmp_ev, sec_ovf_ev, sec_cmp_ev;
    logic [NHALF-1:0] h_en, h_wrap, h_max, h_match;
    logic [HALF_W-1:0] h_val [NHALF];

    always_comb begin
        ctrl_wr   = wr_en && (wr_addr == A_CTRL);
        cnt_wr    = wr_en && (wr_addr == A_COUNT);
        mode_flip = ctrl_wr && (wr_data[B_MODE] != mode_q);
        clr_mask  = (wr_en && wr_addr == A_CLEAR) ? wr_data[FLAG_N-1:0] : '0;
    end

    split_timer_prescaler #(.SEL_W(DIV_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .div_sel(div_q), .tick(tick)
    );

    // run gating and event decode per mode
    always_comb begin
        hi_go    = tick && (state_q != ST_IDLE);
        lo_go    = tick && mode_q && run_lo_q;
        full_max = h_max[0] && h_max[1];
        if (mode_q) begin
            h_en       = {hi_go, lo_go};
            h_wrap     = h_max;
            pri_ovf_ev = hi_go && h_max[1];
            pri_cmp_ev = hi_go && h_match[1];
            sec_ovf_ev = lo_go && h_max[0];
            sec_cmp_ev = lo_go && h_match[0];
        end else begin
            h_en       = {hi_go && h_max[0], hi_go};
            h_wrap     = {full_max, full_max};
            pri_ovf_ev = hi_go && full_max;
            pri_cmp_ev = hi_go && h_match[0] && h_match[1];
            sec_ovf_ev = 1'b0;
            sec_cmp_ev = 1'b0;
        end
        ev_vec = {sec_cmp_ev, sec_ovf_ev, pri_cmp_ev, pri_ovf_ev};
    end

    for (genvar g = 0; g < NHALF; g++) begin : g_half
        split_timer_half #(.W(HALF_W)) u_half (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_val (cnt_wr),
            .new_val  (wr_data[g*HALF_W +: HALF_W]),
            .en       (h_en[g]),
            .wrap     (h_wrap[g]),
            .reload   (reload_q[g*HALF_W +: HALF_W]),
            .compare  (compare_q[g*HALF_W +: HALF_W]),
            .value    (h_val[g]),
            .at_max   (h_max[g]),
            .match    (h_match[g])
        );
    end

    // primary run state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // primary run next state
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = ST_IDLE;
            ST_RUN:  state_d = ST_RUN;
            ST_SHOT: state_d = pri_ovf_ev ? ST_IDLE : ST_SHOT;
            default: state_d = ST_IDLE;
        endcase
        if (ctrl_wr) begin
            if (mode_flip)             state_d = ST_IDLE;
            else if (wr_data[B_RUN])   state_d = ST_RUN;
            else if (wr_data[B_SHOT])  state_d = ST_SHOT;
            else                       state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q  <= '0;
            compare_q <= '0;
            mode_q    <= 1'b0;
            run_lo_q  <= 1'b0;
            ien_pri_q <= 1'b0;
            ien_sec_q <= 1'b0;
            pol_pri_q <= 1'b0;
            oe_pri_q  <= 1'b0;
            pol_sec_q <= 1'b0;
            oe_sec_q  <= 1'b0;
            div_q     <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_RELOAD)  reload_q  <= wr_data;
            if (wr_addr == A_COMPARE) compare_q <= wr_data;
            if (ctrl_wr) begin
                mode_q    <= wr_data[B_MODE];
                run_lo_q  <= mode_flip ? 1'b0 : wr_data[B_RUN_LO];
                ien_pri_q <= wr_data[B_IEN_PRI];
                ien_sec_q <= wr_data[B_IEN_SEC];
                pol_pri_q <= wr_data[B_POL_PRI];
                oe_pri_q  <= wr_data[B_OE_PRI];
                pol_sec_q <= wr_data[B_POL_SEC];
                oe_sec_q  <= wr_data[B_OE_SEC];
                div_q     <= wr_data[B_DIV_LO +: DIV_W];
            end
        end
    end

    // flags: mode change clears, events beat the software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         flags_q <= '0;
        else if (mode_flip) flags_q <= '0;
        else                flags_q <= (flags_q & ~clr_mask) | ev_vec;
    end

    split_timer_wave u_wave_pri (
        .clk(clk), .rst_n(rst_n), .oe(oe_pri_q), .pol(pol_pri_q),
        .toggle(pri_ovf_ev || pri_cmp_ev), .level(pri_out)
    );

    split_timer_wave u_wave_sec (
        .clk(clk), .rst_n(rst_n), .oe(oe_sec_q), .pol(pol_sec_q),
        .toggle(mode_q ? (sec_ovf_ev || sec_cmp_ev) : (pri_ovf_ev || pri_cmp_ev)),
        .level(sec_out)
    );

    always_comb begin
        count_o = {h_val[1], h_val[0]};
        flags_o = flags_q;
        irq_pri = ien_pri_q && (flags_q[1] || flags_q[0]);
        irq_sec = mode_q && ien_sec_q && (flags_q[3] || flags_q[2]);
        pri_oe  = oe_pri_q;
        sec_oe  = oe_sec_q;
    end
endmodule

// File: rtl/split_timer_checker.sv
`timescale 1ns/1ps
module split_timer_checker
    import split_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] count_o,
    input logic [3:0]       flags_o,
    input logic             irq_pri,
    input logic             irq_sec,
    input logic             mode_q,
    input logic             hi_go,
    input logic             pri_ovf_ev,
    input run_state_t       state_q
);
    localparam int HW = CNT_W / 2;

    // R3: low-half wrap never reaches the high half
    p_split_no_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && !hi_go && !(wr_en && wr_addr == A_COUNT))
        |=> $stable(count_o[CNT_W-1:HW]));

    // R5: a stopped wide counter holds its value
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && state_q == ST_IDLE && !(wr_en && wr_addr == A_COUNT))
        |=> $stable(count_o));

    // R6: single shot ends at the primary overflow
    p_shot_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHOT && pri_ovf_ev && !(wr_en && wr_addr == A_CTRL))
        |=> state_q == ST_IDLE);

    // R7: low flags stay clear in wide mode
    p_wide_low_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> flags_o[3:2] == 2'b00);

    // R8: interrupts follow their flags
    p_irq_pri_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pri |-> flags_o[1:0] != 2'b00);
    p_irq_sec_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> !irq_sec);

    // R10: mode flip wipes run state and flags
    p_mode_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CTRL && wr_data[B_MODE] != mode_q)
        |=> (flags_o == 4'b0000 && state_q == ST_IDLE));
endmodule

bind split_timer split_timer_checker #(.CNT_W(2*HALF_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .count_o    (count_o),
    .flags_o    (flags_o),
    .irq_pri    (irq_pri),
    .irq_sec    (irq_sec),
    .mode_q     (mode_q),
    .hi_go      (hi_go),
    .pri_ovf_ev (pri_ovf_ev),
    .state_q    (state_q)
);

// File: tb/split_timer_bench.sv
`timescale 1ns/1ps
module split_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] count_o;
    logic [3:0]  flags_o;
    logic        irq_pri, irq_sec, pri_out, pri_oe, sec_out, sec_oe;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // reference model state
    int m_cnt, m_rel, m_cmp, m_state, m_cyc, m_div, m_flags;
    bit m_mode, m_runlo, m_ienp, m_iens, m_polp, m_oep, m_pols, m_oes, m_lvlp, m_lvls;

    always #2 clk = ~clk;

    split_timer u_split_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count_o(count_o), .flags_o(flags_o), .irq_pri(irq_pri), .irq_sec(irq_sec),
        .pri_out(pri_out), .pri_oe(pri_oe), .sec_out(sec_out), .sec_oe(sec_oe)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_rel = 0; m_cmp = 0; m_state = 0; m_cyc = 0; m_div = 0; m_flags = 0;
        m_mode = 0; m_runlo = 0; m_ienp = 0; m_iens = 0; m_polp = 0; m_oep = 0;
        m_pols = 0; m_oes = 0; m_lvlp = 0; m_lvls = 0;
    endtask

    task automatic model_step();
        int mask, hi, lo, ncnt, nst, nf;
        bit tick, hgo, lgo, pov, pcm, sov, scm, sev;
        mask = (1 << m_div) - 1;
        tick = ((m_cyc & mask) == mask);
        m_cyc = (m_cyc + 1) % 128;
        hgo = tick && (m_state != 0);
        lgo = tick && m_mode && m_runlo;
        pov = 0; pcm = 0; sov = 0; scm = 0;
        ncnt = m_cnt;
        if (!m_mode) begin
            if (hgo) begin
                pov = (m_cnt == 65535);
                pcm = (m_cnt == m_cmp);
                ncnt = pov ? m_rel : m_cnt + 1;
            end
        end else begin
            hi = m_cnt / 256;
            lo = m_cnt % 256;
            if (hgo) begin
                pov = (hi == 255);
                pcm = (hi == m_cmp / 256);
                hi = pov ? m_rel / 256 : hi + 1;
            end
            if (lgo) begin
                sov = (lo == 255);
                scm = (lo == m_cmp % 256);
                lo = sov ? m_rel % 256 : lo + 1;
            end
            ncnt = hi * 256 + lo;
        end
        if (!m_oep) m_lvlp = m_polp;
        else if (pov || pcm) m_lvlp = !m_lvlp;
        sev = m_mode ? (sov || scm) : (pov || pcm);
        if (!m_oes) m_lvls = m_pols;
        else if (sev) m_lvls = !m_lvls;
        nst = m_state;
        if (m_state == 2 && pov) nst = 0;
        nf = m_flags;
        if (wr_en && wr_addr == 3'd4) nf = nf & ~int'(wr_data[3:0]);
        nf = nf | (int'(scm) << 3) | (int'(sov) << 2) | (int'(pcm) << 1) | int'(pov);
        if (wr_en) begin
            case (wr_addr)
                3'd0: ncnt = wr_data;
                3'd1: m_rel = wr_data;
                3'd2: m_cmp = wr_data;
                3'd3: begin
                    if (wr_data[0] != m_mode) begin
                        nst = 0; m_runlo = 0; nf = 0;
                    end else begin
                        m_runlo = wr_data[2];
                        nst = wr_data[1] ? 1 : (wr_data[3] ? 2 : 0);
                    end
                    m_mode = wr_data[0]; m_ienp = wr_data[4]; m_iens = wr_data[5];
                    m_polp = wr_data[6]; m_oep = wr_data[7]; m_pols = wr_data[8];
                    m_oes = wr_data[9]; m_div = int'(wr_data[12:10]);
                end
                default: ;
            endcase
        end
        m_cnt = ncnt; m_state = nst; m_flags = nf;
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2/R3", "count", count_o, m_cnt);
            chk("R7", "flags", flags_o, m_flags);
            chk("R8", "irq_pri", irq_pri, m_ienp && (m_flags & 3) != 0);
            chk("R8", "irq_sec", irq_sec, m_mode && m_iens && (m_flags & 12) != 0);
            chk("R9", "pri_out", pri_out, m_lvlp);
            chk("R9", "sec_out", sec_out, m_lvls);
        end
    end

    function automatic logic [15:0] ctl(bit mode, bit run, bit runlo, bit shot, bit ienp, bit iens,
                                        bit polp, bit oep, bit pols, bit oes, int div);
        return {3'b000, 3'(div), oes, pols, oep, polp, iens, ienp, shot, runlo, run, mode};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_toggles(input int n, output int tp, output int ts);
        logic lp, ls;
        tp = 0; ts = 0; lp = pri_out; ls = sec_out;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pri_out != lp) tp++;
            if (sec_out != ls) ts++;
            lp = pri_out; ls = sec_out;
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int tp, ts;
        logic held;
        logic [15:0] snap;
        wait_cyc(3);
        #1 rst_n = 1'b1;
        wait_cyc(1);
        // R1 reset state
        chk("R1", "count", count_o, 0);
        chk("R1", "flags", flags_o, 0);
        chk("R1", "irqs", {irq_pri, irq_sec}, 0);
        chk("R1", "outputs", {pri_out, sec_out}, 0);

        // R2 wide carry and overflow
        wr(3'd0, 16'h00FE);
        wr(3'd1, 16'hFFF8);
        wr(3'd2, 16'hFFFC);
        wr(3'd3, ctl(0,0,0,0,1,0,0,0,0,1,0));
        wr(3'd3, ctl(0,1,0,0,1,0,0,0,0,1,0));
        wait_cyc(2);
        chk("R2", "wide carry", count_o, 16'h0100);
        wr(3'd0, 16'hFFF0);
        wait_cyc(30);
        chk("R2", "overflow flag", flags_o[0], 1);
        chk("R8", "irq_pri raised", irq_pri, 1);
        wr(3'd4, 16'h000F);

        // R11 rates in split mode
        wr(3'd3, ctl(1,0,0,0,0,0,0,0,0,0,0));
        wr(3'd0, 16'hFCE0);
        wr(3'd1, 16'hFCE0);
        wr(3'd2, 16'h0000);
        wr(3'd3, ctl(1,0,0,0,1,1,0,1,0,1,0));
        wr(3'd3, ctl(1,1,1,0,1,1,0,1,0,1,0));
        count_toggles(128, tp, ts);
        chk("R11", "high overflow toggles", tp, 32);
        chk("R11", "low overflow toggles", ts, 4);

        // R3 low wrap alone
        wr(3'd3, ctl(1,0,1,0,0,0,0,0,0,0,0));
        wr(3'd0, 16'h00FE);
        wait_cyc(2);
        chk("R3", "low wraps without carry", count_o, 16'h00E0);

        // R6 single shot on high half only
        wr(3'd3, ctl(1,0,0,0,0,0,0,0,0,0,0));
        wr(3'd4, 16'h000F);
        wr(3'd0, 16'hFD00);
        wr(3'd3, ctl(1,0,1,1,1,0,0,0,0,0,0));
        wait_cyc(10);
        chk("R6", "high stopped at reload", count_o[15:8], 8'hFC);
        chk("R6", "low keeps running", count_o[7:0], 8'h0A);
        chk("R6", "shot overflow flag", flags_o[0], 1);

        // R4 prescaler
        wr(3'd3, ctl(0,0,0,0,0,0,0,0,0,0,0));
        wr(3'd0, 16'h0000);
        wr(3'd3, ctl(0,1,0,0,0,0,0,0,0,0,2));
        wait_cyc(16);
        chk("R4", "four ticks in sixteen cycles", count_o, 4);

        // R12 coincident compare and overflow
        wr(3'd3, ctl(1,0,0,0,0,0,0,0,0,1,0));
        wr(3'd1, 16'h0000);
        wr(3'd2, 16'hFFFF);
        wr(3'd0, 16'h0000);
        wr(3'd3, ctl(1,0,1,0,0,1,0,0,0,1,0));
        count_toggles(520, tp, ts);
        chk("R12", "single toggle per period", ts, 2);

        // R9 polarity change while enabled
        held = sec_out;
        wr(3'd3, ctl(1,0,0,0,0,1,0,0,~held,1,0));
        wait_cyc(3);
        chk("R9", "polarity ignored while enabled", sec_out, held);
        wr(3'd3, ctl(1,0,0,0,0,1,0,0,1,0,0));
        wait_cyc(2);
        chk("R9", "disabled level follows polarity", sec_out, 1);

        // R10 mode flip with run bits set
        wr(3'd3, ctl(1,0,1,0,0,1,0,0,0,0,0));
        wait_cyc(300);
        chk("R10", "low flags set before flip", flags_o[2], 1);
        wr(3'd3, ctl(0,1,1,0,0,0,0,0,0,0,0));
        chk("R10", "flags cleared", flags_o, 0);
        snap = count_o;
        wait_cyc(5);
        chk("R10", "counter stopped", count_o, snap);

        // R8 secondary enable ignored in wide mode
        wr(3'd0, 16'hFF00);
        wr(3'd1, 16'hFF00);
        wr(3'd2, 16'hFF80);
        wr(3'd3, ctl(0,1,1,0,1,1,0,0,0,0,0));
        wait_cyc(300);
        chk("R8", "irq_sec idle in wide", irq_sec, 0);
        chk("R7", "low flags idle in wide", flags_o[3:2], 0);
        chk("R8", "irq_pri in wide", irq_pri, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule